// File: doc/BRIEF.md
# Microcontroller Byte ALU with Status Flags

This block is the combinational execute stage of a small 8-bit RISC microcontroller. Each evaluation takes an operation code already chosen by the decoder, the raw 16-bit instruction word, the current destination register value, a second register value, the value of a 16-bit register pair, and the incoming status byte. From these it forms the result, the next status byte, and the register indices that the write-back stage should use.

Six byte operations are covered: register OR, OR with an immediate, subtract an immediate together with the carry, one's complement, two's-complement negate, and logical shift right. One word operation adds a 6-bit immediate to one of four upper register pairs. Each operation has its own flag equations, and flags that an operation does not define keep their incoming values. Immediates and register indices are cut from the instruction word inside the block. The block also reports how many cycles the operation occupies, so the sequencer can stall the pipeline.

Status byte layout (bit: flag): 7 I, 6 T, 5 H, 4 S, 3 V, 2 N, 1 Z, 0 C.

Top module: `mcu_alu_exec`

## Requirements
- R1: Operation codes 0 (register OR, operand `i_src`) and 1 (immediate OR) produce dst OR operand, clear V, set N to result bit 7, set Z on a zero result, and leave C and H unchanged.
- R2: Operation code 2 produces dst − K − C_in; C is the borrow out of bit 7, H is the borrow out of bit 3, V is two's-complement overflow of the subtraction, and N and Z follow the result.
- R3: Operation code 3 produces the bitwise inverse of dst, sets C to 1, clears V, N and Z follow the result, and H is unchanged.
- R4: Operation code 4 produces 0 − dst; C is 1 exactly when the result is nonzero, V is 1 only when the result is 0x80, H = result bit 3 OR dst bit 3, and N and Z follow the result.
- R5: Operation code 5 shifts dst right by one with a zero in bit 7; C takes dst bit 0, N is 0, V equals N XOR C, Z follows the result, and H is unchanged.
- R6: Operation code 6 adds K6 to the 16-bit pair value; V = sum bit 15 AND NOT pair bit 15, C = NOT sum bit 15 AND pair bit 15, N = sum bit 15, Z marks a zero 16-bit sum, H is unchanged, and the full sum appears on `o_result`.
- R7: The 8-bit immediate K is {insn[11:8], insn[3:0]}. For codes 1 and 2 the destination index is 16 + insn[7:4]. For codes 0, 3, 4 and 5 it is insn[8:4]. The source index is always {insn[9], insn[3:0]}. Byte results occupy `o_result[7:0]`, and bits 15:8 are zero.
- R8: For code 6 the destination index is the low register 24 + 2·insn[5:4], K6 is {insn[7:6], insn[3:0]}, and `o_wide` is 1. For every other code `o_wide` is 0.
- R9: For every legal code S = N XOR V, and I and T are always passed through unchanged.
- R10: `o_cycles` is 2 for code 6 and 1 for every other code.
- R11: Codes 7 to 15 raise `o_illegal`, return the status byte unchanged and give a zero result. Legal codes keep `o_illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_op | input | 4 | Decoded operation code |
| i_insn | input | 16 | Raw instruction word, used for immediates and indices |
| i_dst | input | 8 | Destination register value |
| i_src | input | 8 | Source register value, used by register OR |
| i_pair | input | 16 | Register pair value {high, low} for the word add |
| i_sreg | input | 8 | Incoming status byte |
| o_result | output | 16 | Result; byte operations use bits 7:0 |
| o_sreg | output | 8 | Next status byte |
| o_dst_idx | output | 5 | Register index to write, the low register for the word add |
| o_src_idx | output | 5 | Source register index |
| o_wide | output | 1 | Write-back covers a register pair |
| o_cycles | output | 2 | Cycles the operation takes |
| o_illegal | output | 1 | Unsupported operation code |

## Verification
The hardest cases to reach are the rare flag boundaries: negate overflow, which only a dst of 0x80 produces; a word add that carries or overflows, which needs the pair near 0xFFFF or 0x7FFF; and a subtract with carry where the carry-in alone causes the borrow. Uniform random stimulus seldom lands on these values. The bench therefore biases random operands toward the edge values 0x00, 0x7F, 0x80 and 0xFF, and adds directed cases for each boundary. Unchanged flags are seen at the ports by presenting incoming status bytes with H, C, I and T set in varied patterns.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW     = 8;
    localparam int WW     = 2 * DW;
    localparam int IW     = 16;
    localparam int RIW    = 5;
    localparam int CYC_W  = 2;
    localparam int K6W    = 6;

    // status byte bit positions
    localparam int SB_C = 0;
    localparam int SB_Z = 1;
    localparam int SB_N = 2;
    localparam int SB_V = 3;
    localparam int SB_S = 4;
    localparam int SB_H = 5;
    localparam int SB_T = 6;
    localparam int SB_I = 7;

    typedef enum logic [3:0] {
        OP_OR   = 4'd0,
        OP_ORI  = 4'd1,
        OP_SBCI = 4'd2,
        OP_COM  = 4'd3,
        OP_NEG  = 4'd4,
        OP_LSR  = 4'd5,
        OP_ADDW = 4'd6
    } alu_op_e;

    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    function automatic flags_t sreg_to_flags(input logic [DW-1:0] sr);
        flags_t f;
        f.h = sr[SB_H];
        f.s = sr[SB_S];
        f.v = sr[SB_V];
        f.n = sr[SB_N];
        f.z = sr[SB_Z];
        f.c = sr[SB_C];
        return f;
    endfunction

    function automatic logic [DW-1:0] flags_to_sreg(input flags_t f, input logic [DW-1:0] keep);
        logic [DW-1:0] r;
        r       = keep;
        r[SB_H] = f.h;
        r[SB_S] = f.s;
        r[SB_V] = f.v;
        r[SB_N] = f.n;
        r[SB_Z] = f.z;
        r[SB_C] = f.c;
        return r;
    endfunction

    function automatic logic [DW-1:0] imm8_of(input logic [IW-1:0] w);
        return {w[11:8], w[3:0]};
    endfunction

    function automatic logic [K6W-1:0] imm6_of(input logic [IW-1:0] w);
        return {w[7:6], w[3:0]};
    endfunction

    function automatic logic is_legal(input logic [3:0] op);
        return op <= OP_ADDW;
    endfunction

endpackage

// File: rtl/alu8_fields.sv
module alu8_fields
    import alu8_pkg::*;
#(
    parameter int HIGH_BANK = 16,
    parameter int PAIR_BASE = 24
) (
    input  logic [3:0]     op,
    input  logic [IW-1:0]  insn,
    output logic [DW-1:0]  k8,
    output logic [K6W-1:0] k6,
    output logic [RIW-1:0] dst_idx,
    output logic [RIW-1:0] src_idx,
    output logic           legal,
    output logic           wide
);
    localparam logic [RIW-1:0] HB = RIW'(HIGH_BANK);
    localparam logic [RIW-1:0] PB = RIW'(PAIR_BASE);

    always_comb begin
        k8      = imm8_of(insn);
        k6      = imm6_of(insn);
        src_idx = {insn[9], insn[3:0]};
        legal   = is_legal(op);
        wide    = (op == OP_ADDW);
        case (op)
            OP_ORI, OP_SBCI: dst_idx = HB + {1'b0, insn[7:4]};
            OP_ADDW:         dst_idx = PB + {2'b00, insn[5:4], 1'b0};
            default:         dst_idx = insn[8:4];
        endcase
    end

    // R8: pair index is always even and inside the pair bank
    always_comb begin
        if (op == OP_ADDW) begin
            p_pair_even_r8: assert (dst_idx[0] == 1'b0 && dst_idx >= PB)
                else $error("pair index %0d", dst_idx);
        end
    end

endmodule

// File: rtl/alu8_byte_unit.sv
module alu8_byte_unit
    import alu8_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  flags_t        f_in,
    output logic [DW-1:0] r,
    output flags_t        f_out
);
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
    localparam int MSB = DW - 1;

    logic nz_upd;

    always_comb begin
        r      = '0;
        f_out  = f_in;
        nz_upd = 1'b1;
        case (op)
            OP_OR, OP_ORI: begin
                r       = a | b;
                f_out.v = 1'b0;
            end
            OP_SBCI: begin
                r       = a - b - {{(DW-1){1'b0}}, f_in.c};
                f_out.h = (~a[3] & b[3]) | (b[3] & r[3]) | (r[3] & ~a[3]);
                f_out.c = (~a[MSB] & b[MSB]) | (b[MSB] & r[MSB]) | (r[MSB] & ~a[MSB]);
                f_out.v = (a[MSB] & ~b[MSB] & ~r[MSB]) | (~a[MSB] & b[MSB] & r[MSB]);
            end
            OP_COM: begin
                r       = ~a;
                f_out.c = 1'b1;
                f_out.v = 1'b0;
            end
            OP_NEG: begin
                r       = '0 - a;
                f_out.c = |r;
                f_out.v = (r == MINV);
                f_out.h = r[3] | a[3];
            end
            OP_LSR: begin
                r       = {1'b0, a[DW-1:1]};
                f_out.c = a[0];
            end
            default: nz_upd = 1'b0;
        endcase
        if (nz_upd) begin
            f_out.n = (op == OP_LSR) ? 1'b0 : r[MSB];
            f_out.z = (r == '0);
            if (op == OP_LSR)
                f_out.v = f_out.n ^ f_out.c;
            f_out.s = f_out.n ^ f_out.v;
        end
    end

    always_comb begin
        if (op == OP_COM) begin
            p_com_inverse_r3: assert (((r ^ a) == {DW{1'b1}}) && f_out.c && !f_out.v)
                else $error("complement mismatch");
        end
        if (op == OP_NEG) begin
            p_neg_sum_r4: assert (((r + a) == '0) && (f_out.v == (a == MINV)))
                else $error("negate mismatch");
        end
        if (op == OP_LSR) begin
            p_lsr_flags_r5: assert (!f_out.n && (f_out.s == f_out.c) && (r[MSB] == 1'b0))
                else $error("shift flags mismatch");
        end
        if (op == OP_SBCI) begin
            p_sbc_total_r2: assert (({1'b0, r} + {1'b0, b} + {{DW{1'b0}}, f_in.c})
                                    == ({f_out.c, {DW{1'b0}}} + {1'b0, a}))
                else $error("subtract total mismatch");
        end
    end

endmodule

// File: rtl/alu8_word_unit.sv
module alu8_word_unit
    import alu8_pkg::*;
(
    input  logic           en,
    input  logic [WW-1:0]  pair,
    input  logic [K6W-1:0] k6,
    input  flags_t         f_in,
    output logic [WW-1:0]  sum,
    output flags_t         f_out
);
    localparam int TOP = WW - 1;

    always_comb begin
        sum     = pair + {{(WW-K6W){1'b0}}, k6};
        f_out   = f_in;
        f_out.v = sum[TOP] & ~pair[TOP];
        f_out.c = ~sum[TOP] & pair[TOP];
        f_out.n = sum[TOP];
        f_out.z = (sum == '0);
        f_out.s = f_out.n ^ f_out.v;
    end

    always_comb begin
        if (en) begin
            p_pair_sum_r6: assert ({f_out.c, sum} == ({1'b0, pair} + {{(WW+1-K6W){1'b0}}, k6}))
                else $error("pair sum mismatch");
        end
    end

endmodule

// File: rtl/mcu_alu_exec.sv
module mcu_alu_exec
    import alu8_pkg::*;
#(
    parameter int HIGH_BANK = 16,
    parameter int PAIR_BASE = 24
) (
    input  logic [3:0]       i_op,
    input  logic [15:0]      i_insn,
    input  logic [7:0]       i_dst,
    input  logic [7:0]       i_src,
    input  logic [15:0]      i_pair,
    input  logic [7:0]       i_sreg,
    output logic [15:0]      o_result,
    output logic [7:0]       o_sreg,
    output logic [4:0]       o_dst_idx,
    output logic [4:0]       o_src_idx,
    output logic             o_wide,
    output logic [1:0]       o_cycles,
    output logic             o_illegal
);
    logic [DW-1:0]  k8;
    logic [K6W-1:0] k6;
    logic           legal;
    logic           wide;
    logic [DW-1:0]  operand;
    logic [DW-1:0]  byte_r;
    logic [WW-1:0]  word_r;
    flags_t         f_cur;
    flags_t         f_byte;
    flags_t         f_word;

    assign f_cur = sreg_to_flags(i_sreg);

    alu8_fields #(
        .HIGH_BANK (HIGH_BANK),
        .PAIR_BASE (PAIR_BASE)
    ) u_fields (
        .op      (i_op),
        .insn    (i_insn),
        .k8      (k8),
        .k6      (k6),
        .dst_idx (o_dst_idx),
        .src_idx (o_src_idx),
        .legal   (legal),
        .wide    (wide)
    );

    assign operand = (i_op == OP_OR) ? i_src : k8;

    alu8_byte_unit u_byte (
        .op    (i_op),
        .a     (i_dst),
        .b     (operand),
        .f_in  (f_cur),
        .r     (byte_r),
        .f_out (f_byte)
    );

    alu8_word_unit u_word (
        .en    (wide),
        .pair  (i_pair),
        .k6    (k6),
        .f_in  (f_cur),
        .sum   (word_r),
        .f_out (f_word)
    );

    always_comb begin
        o_wide    = wide;
        o_illegal = ~legal;
        o_cycles  = wide ? CYC_W'(2) : CYC_W'(1);
        if (!legal) begin
            o_result = '0;
            o_sreg   = i_sreg;
        end else if (wide) begin
            o_result = word_r;
            o_sreg   = flags_to_sreg(f_word, i_sreg);
        end else begin
            o_result = {{(WW-DW){1'b0}}, byte_r};
            o_sreg   = flags_to_sreg(f_byte, i_sreg);
        end
    end

    always_comb begin
        p_keep_it_r9: assert (o_sreg[SB_I] == i_sreg[SB_I] && o_sreg[SB_T] == i_sreg[SB_T])
            else $error("I or T altered");
        if (!o_illegal) begin
            p_sign_rule_r9: assert (o_sreg[SB_S] == (o_sreg[SB_N] ^ o_sreg[SB_V]))
                else $error("S rule broken");
        end else begin
            p_illegal_hold_r11: assert (o_sreg == i_sreg && o_result == '0)
                else $error("illegal op changed state");
        end
        p_cycle_count_r10: assert ((o_cycles == 2'd2) == o_wide && o_cycles != 2'd0)
            else $error("cycle count mismatch");
    end

endmodule

// File: tb/mcu_alu_exec_bench.sv
module mcu_alu_exec_bench;

    logic        clk = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] insn = '0;
    logic [7:0]  dst = '0;
    logic [7:0]  src = '0;
    logic [15:0] pair = '0;
    logic [7:0]  sreg = '0;
    logic [15:0] result;
    logic [7:0]  sreg_o;
    logic [4:0]  dst_idx;
    logic [4:0]  src_idx;
    logic        wide;
    logic [1:0]  cycles;
    logic        illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    mcu_alu_exec u_mcu_alu_exec (
        .i_op      (op),
        .i_insn    (insn),
        .i_dst     (dst),
        .i_src     (src),
        .i_pair    (pair),
        .i_sreg    (sreg),
        .o_result  (result),
        .o_sreg    (sreg_o),
        .o_dst_idx (dst_idx),
        .o_src_idx (src_idx),
        .o_wide    (wide),
        .o_cycles  (cycles),
        .o_illegal (illegal)
    );

    typedef struct packed {
        logic [15:0] res;
        logic [7:0]  sr;
        logic [4:0]  di;
        logic [4:0]  si;
        logic        wd;
        logic [1:0]  cy;
        logic        il;
    } exp_t;

    function automatic exp_t model(logic [3:0] o, logic [15:0] w, logic [7:0] d,
                                   logic [7:0] s, logic [15:0] p, logic [7:0] sr);
        exp_t e;
        logic [7:0]  k;
        logic [7:0]  r;
        logic [8:0]  full;
        logic [4:0]  lo;
        logic [16:0] sum;
        int          sv;
        e.sr  = sr;
        e.res = '0;
        e.il  = 1'b0;
        e.wd  = 1'b0;
        e.cy  = 2'd1;
        e.si  = {w[9], w[3:0]};
        e.di  = w[8:4];
        k     = {w[11:8], w[3:0]};
        r     = '0;
        case (o)
            4'd0, 4'd1: begin
                r = d | ((o == 4'd0) ? s : k);
                e.sr[3] = 1'b0;
                if (o == 4'd1) e.di = 5'd16 + {1'b0, w[7:4]};
            end
            4'd2: begin
                full = {1'b0, d} - {1'b0, k} - {8'd0, sr[0]};
                r = full[7:0];
                e.sr[0] = full[8];
                lo = {1'b0, d[3:0]} - {1'b0, k[3:0]} - {4'd0, sr[0]};
                e.sr[5] = lo[4];
                sv = int'($signed(d)) - int'($signed(k)) - int'(sr[0]);
                e.sr[3] = (sv < -128) || (sv > 127);
                e.di = 5'd16 + {1'b0, w[7:4]};
            end
            4'd3: begin
                r = 8'hFF - d;
                e.sr[0] = 1'b1;
                e.sr[3] = 1'b0;
            end
            4'd4: begin
                r = 8'd0 - d;
                e.sr[0] = (d != 8'd0);
                e.sr[3] = (d == 8'h80);
                e.sr[5] = r[3] | d[3];
            end
            4'd5: begin
                r = d >> 1;
                e.sr[0] = d[0];
                e.sr[3] = d[0];
            end
            4'd6: begin
                sum = {1'b0, p} + {11'd0, w[7:6], w[3:0]};
                e.res = sum[15:0];
                e.sr[0] = sum[16];
                e.sr[3] = !p[15] && sum[15];
                e.sr[2] = sum[15];
                e.sr[1] = (sum[15:0] == 16'd0);
                e.wd = 1'b1;
                e.cy = 2'd2;
                e.di = 5'd24 + {2'b00, w[5:4], 1'b0};
            end
            default: e.il = 1'b1;
        endcase
        if (o <= 4'd5) begin
            e.res = {8'd0, r};
            e.sr[2] = (o == 4'd5) ? 1'b0 : r[7];
            e.sr[1] = (r == 8'd0);
        end
        if (o <= 4'd6)
            e.sr[4] = e.sr[2] ^ e.sr[3];
        return e;
    endfunction

    function automatic string op_tag(logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R1";
            4'd2:       return "R2";
            4'd3:       return "R3";
            4'd4:       return "R4";
            4'd5:       return "R5";
            4'd6:       return "R6";
            default:    return "R11";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h (op=%0d insn=%h dst=%h pair=%h sreg=%h)",
                     tag, what, act, exp, op, insn, dst, pair, sreg);
        end
    endtask

    task automatic apply(logic [3:0] o, logic [15:0] w, logic [7:0] d,
                         logic [7:0] s, logic [15:0] p, logic [7:0] sr);
        exp_t e;
        @(negedge clk);
        op = o; insn = w; dst = d; src = s; pair = p; sreg = sr;
        #2;
        e = model(o, w, d, s, p, sr);
        chk(op_tag(o), "result", result, e.res);
        chk(op_tag(o), "sreg", {8'd0, sreg_o}, {8'd0, e.sr});
        chk("R11", "illegal", {15'd0, illegal}, {15'd0, e.il});
        chk("R10", "cycles", {14'd0, cycles}, {14'd0, e.cy});
        chk("R8", "wide", {15'd0, wide}, {15'd0, e.wd});
        if (!e.il) begin
            chk((o == 4'd6) ? "R8" : "R7", "dst_idx", {11'd0, dst_idx}, {11'd0, e.di});
            chk("R7", "src_idx", {11'd0, src_idx}, {11'd0, e.si});
            chk("R9", "s_rule", {15'd0, sreg_o[4]}, {15'd0, sreg_o[2] ^ sreg_o[3]});
        end
        chk("R9", "i_t_pass", {14'd0, sreg_o[7:6]}, {14'd0, sr[7:6]});
    endtask

    function automatic logic [7:0] edgy8();
        case ($urandom % 6)
            0: return 8'h00;
            1: return 8'h7F;
            2: return 8'h80;
            3: return 8'hFF;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        // initial state: all-zero inputs give a register OR of zeros
        #2;
        chk("R1", "initial_result", result, 16'h0000);
        chk("R1", "initial_sreg", {8'd0, sreg_o}, 16'h0002);
        chk("R11", "initial_illegal", {15'd0, illegal}, 16'h0000);

        // R1 directed: OR keeps C and H
        apply(4'd0, 16'h0000, 8'h00, 8'h00, 16'h0, 8'h21);
        apply(4'd1, 16'h0F5A, 8'h05, 8'h00, 16'h0, 8'hE9);
        // R2: carry-in alone causes the borrow
        apply(4'd2, 16'h0000, 8'h00, 8'h00, 16'h0, 8'h01);
        apply(4'd2, 16'h0301, 8'h80, 8'h00, 16'h0, 8'h00);
        // R3: complement of all ones gives zero
        apply(4'd3, 16'h01F0, 8'hFF, 8'h00, 16'h0, 8'h20);
        // R4: negate corners
        apply(4'd4, 16'h0010, 8'h80, 8'h00, 16'h0, 8'h00);
        apply(4'd4, 16'h0010, 8'h00, 8'h00, 16'h0, 8'h3F);
        // R5: shift out the only set bit
        apply(4'd5, 16'h0150, 8'h01, 8'h00, 16'h0, 8'h20);
        // R6: pair carries to zero and overflows at 0x7FFF
        apply(4'd6, 16'h0001, 8'h00, 8'h00, 16'hFFFF, 8'h00);
        apply(4'd6, 16'h0031, 8'h00, 8'h00, 16'h7FFF, 8'h20);
        apply(4'd6, 16'h00FF, 8'h00, 8'h00, 16'h1234, 8'hC0);
        // R11: unsupported codes
        apply(4'd7, 16'hFFFF, 8'h55, 8'h00, 16'h0, 8'hA5);
        apply(4'd15, 16'h1234, 8'h00, 8'h00, 16'h0, 8'h5A);

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] o;
            o = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom_range(0, 6));
            apply(o, 16'($urandom), edgy8(), edgy8(),
                  ($urandom % 3 == 0) ? {edgy8(), edgy8()} : 16'($urandom),
                  8'($urandom));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule